// File: doc/BRIEF.md
# Multi-Channel General-Purpose Timer

This block is a bank of independent up-counting timers reached through a simple word-wide register bus. Each channel owns four registers: control, clock select, counter and compare. A channel counts on tick-enable pulses taken from one of two sources, a fast system tick or a slow 32 kHz tick, optionally halved by a divide-by-2 stage. When the count reaches the compare value the channel raises its pending flag. What happens next depends on the operating mode: the channel stops, reloads to zero, or keeps running freely.

The pending flags of all channels sit in one shared status word, which is cleared by writing ones to it. A shared enable word masks which flags reach the single interrupt output. The tick sources are not generated here. They arrive as single-cycle enables that are already in the core clock domain. Software starts a channel by writing compare, clock select and then control, with the clear bit set to restart the count from zero.

Top module: `gp_timer_bank`

## Requirements
- R1: After reset every register reads 0 and `irq` is 0.
- R2: Channel n (1..NUM_CH) places control at byte address 16*n, clock select at 16*n+4, counter at 16*n+8 and compare at 16*n+12. The interrupt-enable word is at 0x00 and the pending/acknowledge word at 0x08, with channel n on bit n-1. Compare and clock select read back what was written (clock select keeps bits 4 and 0). Every other address reads 0.
- R3: Control bit 1 is a clear strobe. A write with it set zeroes the counter on that same clock edge, whatever the enable bit says, and bit 1 always reads back as 0.
- R4: While control bit 0 (enable) is 1, the counter advances by one on each counting tick. The tick comes from `tick_fast` when clock-select bit 4 is 0 and from `tick_slow` when it is 1. Ticks on the other source have no effect. While enable is 0 the counter holds.
- R5: With clock-select bit 0 set (divide-by-2), the counter advances on every second tick of the selected source, starting with the second tick after a clear.
- R6: Control bits [5:4] = 0 select one-shot mode. When the counter steps to the compare value, the pending flag sets, the enable bit clears and the counter holds at the compare value.
- R7: Control bits [5:4] = 1 select repeat mode. When the counter steps to the compare value, the pending flag sets and the counter returns to 0 and keeps counting.
- R8: Control bits [5:4] = 3 (and the unused code 2) select free-run mode. Reaching compare sets the pending flag without stopping or reloading, and the counter wraps from 2^CNT_W-1 to 0.
- R9: Writing the acknowledge word clears every pending flag whose bit is 1 and leaves flags under 0 bits unchanged. A match arriving in the same cycle wins.
- R10: `irq` is the OR over channels of pending AND enable. A pending flag still latches while its enable bit is 0.
- R11: The counter register is read-only: writes to it leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for one word |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_fast | input | 1 | Tick enable of the fast system source |
| tick_slow | input | 1 | Tick enable of the 32 kHz source |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with six channels and a 12-bit counter (CNT_W = 12). The narrow counter brings the free-run wrap at 4096 within a few thousand cycles. The bench then sweeps every channel through every mode, both tick sources and both divider settings at several tick counts. For each case the expected count, pending bit and enable bit are worked out arithmetically from the tick count and the compare value. During every sweep the non-selected source is pulsed between ticks, so any leakage from the wrong source would change the count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_ONCE = 2'd0,
    MODE_LOOP = 2'd1,
    MODE_RSVD = 2'd2,
    MODE_FREE = 2'd3
  } tmr_mode_e;

  localparam int unsigned CTL_EN_BIT   = 0;
  localparam int unsigned CTL_CLR_BIT  = 1;
  localparam int unsigned CTL_MODE_LSB = 4;
  localparam int unsigned CKS_DIV_BIT  = 0;
  localparam int unsigned CKS_SRC_BIT  = 4;

  localparam logic [1:0] SUB_CTRL = 2'd0;
  localparam logic [1:0] SUB_CKS  = 2'd1;
  localparam logic [1:0] SUB_CNT  = 2'd2;
  localparam logic [1:0] SUB_CMP  = 2'd3;

endpackage

// File: rtl/tmr_tick_gate.sv
module tmr_tick_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_fast,
  input  logic tick_slow,
  input  logic src_slow,
  input  logic div2,
  input  logic run,
  input  logic restart,
  output logic step
);

  logic tick_sel;
  logic phase_q, phase_d;

  assign tick_sel = src_slow ? tick_slow : tick_fast;

  always_comb begin
    phase_d = phase_q;
    if (restart) begin
      phase_d = 1'b0;
    end else if (run && tick_sel) begin
      phase_d = ~phase_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign step = run && tick_sel && (!div2 || phase_q);

  assert_half_rate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && div2 && !restart) |=> !step || !div2 || !phase_q || restart)
    else $error("divide-by-2 stepped on two consecutive ticks");

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_we,
  input  logic        cks_we,
  input  logic        cmp_we,
  input  logic [31:0] wdata,
  input  logic        tick_fast,
  input  logic        tick_slow,
  output logic        hit,
  output logic [31:0] ctrl_word,
  output logic [31:0] cks_word,
  output logic [31:0] cnt_word,
  output logic [31:0] cmp_word
);

  logic             en_q, en_d;
  tmr_mode_e        mode_q, mode_d;
  logic             src_q, src_d;
  logic             div_q, div_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic [CNT_W-1:0] cnt_inc;
  logic             step;
  logic             restart;

  assign restart = ctrl_we && wdata[CTL_CLR_BIT];

  tmr_tick_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_fast(tick_fast),
    .tick_slow(tick_slow),
    .src_slow (src_q),
    .div2     (div_q),
    .run      (en_q),
    .restart  (restart),
    .step     (step)
  );

  assign cnt_inc = cnt_q + CNT_W'(1);

  always_comb begin
    en_d   = en_q;
    mode_d = mode_q;
    src_d  = src_q;
    div_d  = div_q;
    cnt_d  = cnt_q;
    cmp_d  = cmp_q;
    hit    = 1'b0;
    if (step) begin
      cnt_d = cnt_inc;
      if (cnt_inc == cmp_q) begin
        hit = 1'b1;
        case (mode_q)
          MODE_ONCE: en_d  = 1'b0;
          MODE_LOOP: cnt_d = '0;
          default:   cnt_d = cnt_inc;
        endcase
      end
    end
    if (cks_we) begin
      src_d = wdata[CKS_SRC_BIT];
      div_d = wdata[CKS_DIV_BIT];
    end
    if (cmp_we) begin
      cmp_d = wdata[CNT_W-1:0];
    end
    if (ctrl_we) begin
      en_d   = wdata[CTL_EN_BIT];
      mode_d = tmr_mode_e'(wdata[CTL_MODE_LSB +: 2]);
      if (wdata[CTL_CLR_BIT]) begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= MODE_ONCE;
      src_q  <= 1'b0;
      div_q  <= 1'b0;
      cnt_q  <= '0;
      cmp_q  <= '0;
    end else begin
      en_q   <= en_d;
      mode_q <= mode_d;
      src_q  <= src_d;
      div_q  <= div_d;
      cnt_q  <= cnt_d;
      cmp_q  <= cmp_d;
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTL_EN_BIT] = en_q;
    ctrl_word[CTL_MODE_LSB +: 2] = mode_q;
    cks_word = '0;
    cks_word[CKS_SRC_BIT] = src_q;
    cks_word[CKS_DIV_BIT] = div_q;
    cnt_word = '0;
    cnt_word[CNT_W-1:0] = cnt_q;
    cmp_word = '0;
    cmp_word[CNT_W-1:0] = cmp_q;
  end

  assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0))
    else $error("clear strobe did not zero the counter");

  assert_hold_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !ctrl_we) |=> $stable(cnt_q))
    else $error("disabled channel changed its count");

  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_we && en_q) |=> ((cnt_q - $past(cnt_q)) <= CNT_W'(1)) || (cnt_q == '0))
    else $error("counter moved by more than one");

  assert_oneshot_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode_q == MODE_ONCE && !ctrl_we) |=> !en_q && (cnt_q == cmp_q))
    else $error("one-shot did not stop at compare");

  assert_repeat_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode_q == MODE_LOOP && !ctrl_we) |=> (cnt_q == '0) && en_q)
    else $error("repeat did not reload to zero");

endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
  parameter int unsigned NUM_CH = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ien_we,
  input  logic              ack_we,
  input  logic [31:0]       wdata,
  input  logic [NUM_CH-1:0] hit,
  output logic [NUM_CH-1:0] ien_q,
  output logic [NUM_CH-1:0] pend_q,
  output logic              irq
);

  logic [NUM_CH-1:0] ien_d;
  logic [NUM_CH-1:0] pend_d;
  logic [NUM_CH-1:0] ack_mask;

  assign ack_mask = ack_we ? wdata[NUM_CH-1:0] : '0;

  always_comb begin
    ien_d  = ien_we ? wdata[NUM_CH-1:0] : ien_q;
    pend_d = (pend_q & ~ack_mask) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= '0;
      pend_q <= '0;
    end else begin
      ien_q  <= ien_d;
      pend_q <= pend_d;
    end
  end

  assign irq = |(pend_q & ien_q);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    assert_ack_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend_q[i]) |-> $past(ack_we && wdata[i]))
      else $error("pending flag dropped without acknowledge");

    assert_latch_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> pend_q[i])
      else $error("match did not latch pending flag");
  end

endmodule

// File: rtl/gp_timer_bank.sv
module gp_timer_bank
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              tick_fast,
  input  logic              tick_slow,
  output logic              irq
);

  localparam int unsigned IDX_W = ADDR_W - 4;

  logic [1:0]       rst_sync_q;
  logic             rst_n_i;
  logic [IDX_W-1:0] ch_idx;
  logic [1:0]       sub;
  logic             glob_sel;
  logic             ien_we;
  logic             ack_we;

  logic [NUM_CH-1:0] ctrl_we, cks_we, cmp_we, hit;
  logic [31:0]       rd_ctrl [NUM_CH];
  logic [31:0]       rd_cks  [NUM_CH];
  logic [31:0]       rd_cnt  [NUM_CH];
  logic [31:0]       rd_cmp  [NUM_CH];
  logic [NUM_CH-1:0] ien_q, pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_i = rst_sync_q[1];

  assign ch_idx   = bus_addr[ADDR_W-1:4];
  assign sub      = bus_addr[3:2];
  assign glob_sel = (ch_idx == '0);
  assign ien_we   = bus_we && glob_sel && (sub == 2'd0);
  assign ack_we   = bus_we && glob_sel && (sub == 2'd2);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic sel;
    assign sel        = (ch_idx == IDX_W'(i + 1));
    assign ctrl_we[i] = bus_we && sel && (sub == SUB_CTRL);
    assign cks_we[i]  = bus_we && sel && (sub == SUB_CKS);
    assign cmp_we[i]  = bus_we && sel && (sub == SUB_CMP);

    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n_i),
      .ctrl_we  (ctrl_we[i]),
      .cks_we   (cks_we[i]),
      .cmp_we   (cmp_we[i]),
      .wdata    (bus_wdata),
      .tick_fast(tick_fast),
      .tick_slow(tick_slow),
      .hit      (hit[i]),
      .ctrl_word(rd_ctrl[i]),
      .cks_word (rd_cks[i]),
      .cnt_word (rd_cnt[i]),
      .cmp_word (rd_cmp[i])
    );
  end

  tmr_irq_ctrl #(.NUM_CH(NUM_CH)) u_irq (
    .clk   (clk),
    .rst_n (rst_n_i),
    .ien_we(ien_we),
    .ack_we(ack_we),
    .wdata (bus_wdata),
    .hit   (hit),
    .ien_q (ien_q),
    .pend_q(pend_q),
    .irq   (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (glob_sel) begin
      if (sub == 2'd0) bus_rdata[NUM_CH-1:0] = ien_q;
      if (sub == 2'd2) bus_rdata[NUM_CH-1:0] = pend_q;
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_idx == IDX_W'(i + 1)) begin
        case (sub)
          SUB_CTRL: bus_rdata = rd_ctrl[i];
          SUB_CKS:  bus_rdata = rd_cks[i];
          SUB_CNT:  bus_rdata = rd_cnt[i];
          default:  bus_rdata = rd_cmp[i];
        endcase
      end
    end
  end

  assert_one_writer_R2: assert property (@(posedge clk) disable iff (!rst_n_i)
    $onehot0({ctrl_we, cks_we, cmp_we, ien_we, ack_we}))
    else $error("one bus write reached two registers");

  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n_i)
    $past(ien_we && bus_wdata[NUM_CH-1:0] == '0) |-> !irq)
    else $error("interrupt raised with all enables off");

endmodule

// File: tb/sim_gp_timer_bank.sv
module sim_gp_timer_bank;

  localparam int    NCH     = 6;
  localparam int    CW      = 12;
  localparam int    AW      = 8;
  localparam time   CLK_PER = 10ns;
  localparam int    CMPV    = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_we;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic          tick_fast, tick_slow;
  logic          irq;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done   = 0;

  always #(CLK_PER / 2) clk = ~clk;

  gp_timer_bank #(.NUM_CH(NCH), .CNT_W(CW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_fast(tick_fast), .tick_slow(tick_slow), .irq(irq)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=%0d cycles exp=<150000", cycles);
      summary();
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] ra(input int ch, input int sub);
    return AW'(ch * 16 + sub * 4);
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // one tick on the chosen source, then one pulse on the other source
  task automatic pulse(input int src);
    @(negedge clk);
    if (src == 1) tick_slow = 1'b1; else tick_fast = 1'b1;
    @(negedge clk);
    tick_fast = 1'b0; tick_slow = 1'b0;
    if (src == 1) tick_fast = 1'b1; else tick_slow = 1'b1;
    @(negedge clk);
    tick_fast = 1'b0; tick_slow = 1'b0;
  endtask

  initial begin
    logic [31:0] d;
    int modes [3];
    int tcnt  [3];
    modes = '{0, 1, 3};
    tcnt  = '{2, 5, 8};
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    tick_fast = 1'b0; tick_slow = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int ch = 1; ch <= NCH; ch++) begin
      for (int s = 0; s < 4; s++) begin
        rd(ra(ch, s), d); check("R1 reset reg", d, 32'h0);
      end
    end
    rd(8'h00, d); check("R1 reset ien", d, 32'h0);
    rd(8'h08, d); check("R1 reset pend", d, 32'h0);
    check("R1 reset irq", {31'h0, irq}, 32'h0);

    // R2 map and readback
    for (int ch = 1; ch <= NCH; ch++) begin
      wr(ra(ch, 3), 32'(ch * 32'h111) & 32'hFFF);
      wr(ra(ch, 1), 32'hFFFF_FFFF);
    end
    for (int ch = 1; ch <= NCH; ch++) begin
      rd(ra(ch, 3), d); check("R2 compare readback", d, 32'(ch * 32'h111) & 32'hFFF);
      rd(ra(ch, 1), d); check("R2 clock-select readback", d, 32'h11);
    end
    rd(8'h04, d); check("R2 unmapped 0x04", d, 32'h0);
    rd(8'h0C, d); check("R2 unmapped 0x0C", d, 32'h0);
    rd(8'h70, d); check("R2 unmapped 0x70", d, 32'h0);
    rd(8'hF8, d); check("R2 unmapped 0xF8", d, 32'h0);

    // R4..R8 sweep: every channel, mode, source, divider, tick count
    for (int ch = 1; ch <= NCH; ch++) begin
      for (int mi = 0; mi < 3; mi++) begin
        for (int dv = 0; dv < 2; dv++) begin
          for (int sr = 0; sr < 2; sr++) begin
            for (int ti = 0; ti < 3; ti++) begin
              int steps, ecnt, epend, een;
              wr(8'h08, 32'h3F);
              wr(ra(ch, 3), CMPV);
              wr(ra(ch, 1), 32'((sr << 4) | dv));
              wr(ra(ch, 0), 32'((modes[mi] << 4) | 3));
              for (int k = 0; k < tcnt[ti]; k++) pulse(sr);
              steps = (dv == 1) ? tcnt[ti] / 2 : tcnt[ti];
              epend = (steps >= CMPV) ? 1 : 0;
              een   = 1;
              if (modes[mi] == 0) begin
                ecnt = epend ? CMPV : steps;
                een  = epend ? 0 : 1;
              end else if (modes[mi] == 1) begin
                ecnt = steps % CMPV;
              end else begin
                ecnt = steps;
              end
              rd(ra(ch, 2), d);
              check(modes[mi] == 0 ? "R6 one-shot count" :
                    modes[mi] == 1 ? "R7 repeat count" : "R8 free-run count",
                    d, 32'(ecnt));
              rd(8'h08, d);
              check("R5/R10 pending bit", d, 32'(epend << (ch - 1)));
              rd(ra(ch, 0), d);
              check("R3/R4 control readback", d, 32'((modes[mi] << 4) | een));
            end
          end
        end
      end
    end

    // R8 wrap at 2^CW in free-run, held tick
    wr(8'h08, 32'h3F);
    wr(ra(2, 3), 5);
    wr(ra(2, 1), 0);
    wr(ra(2, 0), 32'h33);
    @(negedge clk); tick_fast = 1'b1;
    repeat ((1 << CW) + 3) @(negedge clk);
    tick_fast = 1'b0;
    rd(ra(2, 2), d); check("R8 wrap count", d, 32'd3);
    rd(8'h08, d);    check("R8 pending after wrap", d, 32'h02);

    // R11 counter write ignored
    wr(ra(2, 2), 32'hABC);
    rd(ra(2, 2), d); check("R11 counter write ignored", d, 32'd3);

    // R10 masking and R9 acknowledge
    check("R10 irq masked while pending", {31'h0, irq}, 32'h0);
    wr(8'h00, 32'h01);
    check("R10 other channel enabled", {31'h0, irq}, 32'h0);
    wr(8'h00, 32'h02);
    check("R10 irq raised", {31'h0, irq}, 32'h1);
    rd(8'h00, d); check("R2 ien readback", d, 32'h02);
    wr(8'h08, 32'h0);
    rd(8'h08, d); check("R9 zero ack no effect", d, 32'h02);
    wr(8'h08, 32'h3D);
    rd(8'h08, d); check("R9 ack other bits no effect", d, 32'h02);
    wr(8'h08, 32'h02);
    rd(8'h08, d); check("R9 ack clears", d, 32'h0);
    check("R9 irq drops", {31'h0, irq}, 32'h0);

    // R3 clear without enable
    wr(ra(2, 0), 32'h2);
    rd(ra(2, 2), d); check("R3 clear with enable 0", d, 32'h0);
    rd(ra(2, 0), d); check("R3 clear bit reads 0", d, 32'h0);

    // R4 disabled channel holds
    wr(ra(3, 1), 0);
    wr(ra(3, 0), 32'h12);
    for (int k = 0; k < 4; k++) pulse(0);
    rd(ra(3, 2), d); check("R4 disabled holds", d, 32'h0);

    // R4 ticks ignored on other source only
    wr(ra(3, 3), 32'hFFF);
    wr(ra(3, 0), 32'h33);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); tick_slow = 1'b1;
      @(negedge clk); tick_slow = 1'b0;
    end
    rd(ra(3, 2), d); check("R4 other source ignored", d, 32'h0);

    done = 1;
    summary();
  end

endmodule